// File: doc/BRIEF.md
# Capture/Reload Interval Timer

A 16-bit up-counter paired with a single 16-bit holding register whose role depends on the selected mode. In reload mode the holding register supplies the value loaded into the count whenever it wraps past FFFFh. In capture mode the count runs freely and wraps to zero; a falling edge on the trigger pin, when enabled, snapshots the live count into the holding register and raises an external-event flag.

The count advances either on a timebase tick (the system clock itself or one tick every twelve system clocks, chosen by an input pin) or on falling edges of an external count pin. Both external pins pass through a two-flop synchroniser before their falling edges are detected. A byte-wide register port gives software access to the control register, the holding register and the count. Software clears the two flags. An interrupt line reports either flag when enabled.

Top module: `capture_reload_timer`

## Requirements
- R1: After reset every register reads 0 and irq_o is low.
- R2: With run (control bit 2) at 0 the count holds its value.
- R3: In reload mode (control bit 0 = 0) a step from FFFFh loads the count from the holding register and sets the overflow flag (control bit 7).
- R4: In capture mode (control bit 0 = 1) a step from FFFFh gives 0000h, sets the overflow flag and leaves the holding register unchanged.
- R5: In capture mode with the trigger enable (control bit 3) set, a falling edge on trig_i copies the count into the holding register and sets the external flag (control bit 6).
- R6: With the trigger enable clear, edges on trig_i leave the holding register and the external flag unchanged.
- R7: In timer mode (control bit 1 = 0) the count steps every clock when clk_sel_i is 1 and once per 12 clocks when clk_sel_i is 0.
- R8: In counter mode (control bit 1 = 1) the count steps once per falling edge on cnt_pin_i and ignores the timebase.
- R9: Flags stay set until software writes 0 to them; irq_o is irq_en_i AND (overflow flag OR external flag).
- R10: When a capture and a count step occur in the same cycle, the holding register receives the count before the step.
- R11: Register addresses: 0 control, 1 holding low byte, 2 holding high byte, 3 count low byte, 4 count high byte; control bits 5:4 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |
| clk_sel_i | input | 1 | 1: step per clock, 0: step per 12 clocks |
| trig_i | input | 1 | Capture trigger pin, falling edge active |
| cnt_pin_i | input | 1 | External count pin, falling edge active |
| irq_en_i | input | 1 | Interrupt enable |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions take the external pins as asynchronous levels that stay put long enough for the synchroniser to resolve them, and take register writes as single-cycle strobes that do not collide with a wrap they are meant to observe. The stimulus holds each pin level for at least three clocks, drives all inputs on the falling clock edge, and stops the timer or reads back in windows where no wrap coincides with a count write.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int CNT_W = 16;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_HOLD_L = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_HOLD_H = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CNT_L  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_CNT_H  = 3'd4;

  typedef struct packed {
    logic       ovf;
    logic       ext;
    logic [1:0] rsv;
    logic       trig_en;
    logic       run;
    logic       ext_cnt;
    logic       cap_mode;
  } ctrl_t;
endpackage

// File: rtl/pin_fall_detect.sv
module pin_fall_detect #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic fall_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];

  assert_single_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int DIV = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pre_q <= '0;
    else if (!run_i)      pre_q <= '0;
    else if (pre_q == LAST) pre_q <= '0;
    else                  pre_q <= pre_q + 1'b1;
  end

  assign tick_o = run_i & (pre_q == LAST);

  assert_pre_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= LAST);
  assert_tick_spacing_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && DIV > 1) |=> !tick_o);
endmodule

// File: rtl/capture_reload_timer.sv
module capture_reload_timer
  import timer_pkg::*;
#(
  parameter int DIV         = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              clk_sel_i,
  input  logic              trig_i,
  input  logic              cnt_pin_i,
  input  logic              irq_en_i,
  output logic              irq_o
);
  localparam int NPINS = 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] cnt_q, hold_q;

  // pin 0: trigger, pin 1: count
  logic [NPINS-1:0] pins, falls;
  assign pins = {cnt_pin_i, trig_i};

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    pin_fall_detect #(.STAGES(SYNC_STAGES)) u_fall (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pin_i (pins[g]),
      .fall_o(falls[g])
    );
  end

  logic div_tick;
  tick_divider #(.DIV(DIV)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (ctrl_q.run & ~ctrl_q.ext_cnt),
    .tick_o(div_tick)
  );

  logic wr_ctrl, wr_hold_l, wr_hold_h, wr_cnt_l, wr_cnt_h, wr_cnt;
  assign wr_ctrl   = reg_wr_i && reg_addr_i == ADDR_CTRL;
  assign wr_hold_l = reg_wr_i && reg_addr_i == ADDR_HOLD_L;
  assign wr_hold_h = reg_wr_i && reg_addr_i == ADDR_HOLD_H;
  assign wr_cnt_l  = reg_wr_i && reg_addr_i == ADDR_CNT_L;
  assign wr_cnt_h  = reg_wr_i && reg_addr_i == ADDR_CNT_H;
  assign wr_cnt    = wr_cnt_l | wr_cnt_h;

  logic tick, step, wrap, cap_ev;
  assign tick   = ctrl_q.ext_cnt ? falls[1] : (clk_sel_i | div_tick);
  assign step   = ctrl_q.run & tick;
  assign wrap   = step & (cnt_q == CNT_MAX);
  assign cap_ev = ctrl_q.run & ctrl_q.cap_mode & ctrl_q.trig_en & falls[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (wr_cnt) begin
      if (wr_cnt_l) cnt_q[7:0]  <= reg_wdata_i;
      if (wr_cnt_h) cnt_q[15:8] <= reg_wdata_i;
    end else if (wrap) begin
      cnt_q <= ctrl_q.cap_mode ? '0 : hold_q;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // capture takes the pre-step count and wins over a software write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
    end else if (cap_ev) begin
      hold_q <= cnt_q;
    end else begin
      if (wr_hold_l) hold_q[7:0]  <= reg_wdata_i;
      if (wr_hold_h) hold_q[15:8] <= reg_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.trig_en  <= reg_wdata_i[3];
        ctrl_q.run      <= reg_wdata_i[2];
        ctrl_q.ext_cnt  <= reg_wdata_i[1];
        ctrl_q.cap_mode <= reg_wdata_i[0];
      end
      ctrl_q.rsv <= '0;
      ctrl_q.ovf <= (wr_ctrl ? reg_wdata_i[7] : ctrl_q.ovf) | wrap;
      ctrl_q.ext <= (wr_ctrl ? reg_wdata_i[6] : ctrl_q.ext) | cap_ev;
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      ADDR_CTRL:   reg_rdata_o = ctrl_q;
      ADDR_HOLD_L: reg_rdata_o = hold_q[7:0];
      ADDR_HOLD_H: reg_rdata_o = hold_q[15:8];
      ADDR_CNT_L:  reg_rdata_o = cnt_q[7:0];
      ADDR_CNT_H:  reg_rdata_o = cnt_q[15:8];
      default:     reg_rdata_o = '0;
    endcase
  end

  assign irq_o = irq_en_i & (ctrl_q.ovf | ctrl_q.ext);

  assert_hold_when_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.run && !wr_cnt) |=> $stable(cnt_q));
  assert_reload_on_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && !ctrl_q.cap_mode && !wr_cnt) |=> (cnt_q == $past(hold_q)) && ctrl_q.ovf);
  assert_free_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && ctrl_q.cap_mode && !wr_cnt) |=> (cnt_q == '0) && ctrl_q.ovf);
  assert_capture_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_ev |=> (hold_q == $past(cnt_q)) && ctrl_q.ext);
  assert_hold_untouched_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_ev && !wr_hold_l && !wr_hold_h) |=> $stable(hold_q));
  assert_flag_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.ovf && !wr_ctrl) |=> ctrl_q.ovf);
endmodule

// File: tb/capture_reload_timer_tb.sv
module capture_reload_timer_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_wr_i = 1'b0;
  logic [2:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       clk_sel_i = 1'b1;
  logic       trig_i = 1'b1;
  logic       cnt_pin_i = 1'b1;
  logic       irq_en_i = 1'b0;
  logic       irq_o;

  int n_checks = 0;
  int n_fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  capture_reload_timer dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .clk_sel_i(clk_sel_i),
    .trig_i(trig_i), .cnt_pin_i(cnt_pin_i), .irq_en_i(irq_en_i), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic wr16(input logic [2:0] a_lo, input logic [15:0] v);
    wr(a_lo, v[7:0]);
    wr(a_lo + 3'd1, v[15:8]);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic rd16(input logic [2:0] a_lo, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(a_lo, lo);
    rd(a_lo + 3'd1, hi);
    v = {hi, lo};
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      check("R1 reset reg", {8'h0, d}, 16'h0);
    end
    check("R1 irq", {15'h0, irq_o}, 16'h0);
  endtask

  task automatic t_fast_and_off;
    logic [15:0] v;
    clk_sel_i = 1'b1;
    wr16(3'd3, 16'h0000);
    wr(3'd0, 8'h04);
    wait_cyc(10);
    rd16(3'd3, v);
    check("R7 fast timebase", v, 16'd10);
    wr(3'd0, 8'h00);
    wait_cyc(5);
    rd16(3'd3, v);
    check("R2 stopped count", v, 16'd11);
  endtask

  task automatic t_slow;
    logic [15:0] v;
    clk_sel_i = 1'b0;
    wr16(3'd3, 16'h0000);
    wr(3'd0, 8'h04);
    wait_cyc(23);
    rd16(3'd3, v);
    check("R7 div12 before tick", v, 16'd1);
    wait_cyc(1);
    rd16(3'd3, v);
    check("R7 div12 second tick", v, 16'd2);
    wr(3'd0, 8'h00);
    clk_sel_i = 1'b1;
  endtask

  task automatic t_reload;
    logic [15:0] v;
    logic [7:0]  c;
    wr16(3'd1, 16'hFFF0);
    wr16(3'd3, 16'hFFFE);
    wr(3'd0, 8'h04);
    wait_cyc(2);
    rd16(3'd3, v);
    check("R3 reload value", v, 16'hFFF0);
    rd(3'd0, c);
    check("R3 overflow flag", {8'h0, c}, 16'h0084);
    irq_en_i = 1'b1;
    #1;
    check("R9 irq on overflow", {15'h0, irq_o}, 16'h1);
    wait_cyc(4);
    rd(3'd0, c);
    check("R9 flag sticky", {15'h0, c[7]}, 16'h1);
    wr(3'd0, 8'h00);
    #1;
    rd(3'd0, c);
    check("R9 software clear", {8'h0, c}, 16'h0);
    check("R9 irq drops", {15'h0, irq_o}, 16'h0);
    irq_en_i = 1'b0;
  endtask

  task automatic t_free_wrap;
    logic [15:0] v;
    logic [7:0]  c;
    wr16(3'd1, 16'h1234);
    wr16(3'd3, 16'hFFFE);
    wr(3'd0, 8'h05);
    wait_cyc(2);
    rd16(3'd3, v);
    check("R4 wrap to zero", v, 16'h0000);
    rd16(3'd1, v);
    check("R4 holding kept", v, 16'h1234);
    rd(3'd0, c);
    check("R4 overflow flag", {15'h0, c[7]}, 16'h1);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_capture;
    logic [15:0] v;
    logic [7:0]  c;
    wr16(3'd1, 16'h0000);
    wr16(3'd3, 16'h0100);
    wr(3'd0, 8'h0F);
    trig_i = 1'b0;
    wait_cyc(5);
    rd16(3'd1, v);
    check("R5 captured count", v, 16'h0100);
    rd(3'd0, c);
    check("R5 external flag", {8'h0, c}, 16'h004F);
    rd16(3'd3, v);
    check("R8 count ignores clock", v, 16'h0100);
    irq_en_i = 1'b1;
    #1;
    check("R9 irq on ext flag", {15'h0, irq_o}, 16'h1);
    irq_en_i = 1'b0;
    #1;
    check("R9 irq gated", {15'h0, irq_o}, 16'h0);
    trig_i = 1'b1;
    wait_cyc(4);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_ignored;
    logic [15:0] v;
    logic [7:0]  c;
    wr16(3'd1, 16'hAAAA);
    wr(3'd0, 8'h07);
    trig_i = 1'b0;
    wait_cyc(5);
    rd16(3'd1, v);
    check("R6 holding unchanged", v, 16'hAAAA);
    rd(3'd0, c);
    check("R6 no ext flag", {15'h0, c[6]}, 16'h0);
    trig_i = 1'b1;
    wait_cyc(4);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_counter_and_same_cycle;
    logic [15:0] v;
    wr16(3'd3, 16'h0005);
    wr(3'd0, 8'h0F);
    for (int i = 0; i < 3; i++) begin
      cnt_pin_i = 1'b0; wait_cyc(3);
      cnt_pin_i = 1'b1; wait_cyc(3);
    end
    rd16(3'd3, v);
    check("R8 three pin edges", v, 16'h0008);
    trig_i = 1'b0;
    cnt_pin_i = 1'b0;
    wait_cyc(5);
    rd16(3'd1, v);
    check("R10 pre-step capture", v, 16'h0008);
    rd16(3'd3, v);
    check("R10 count stepped", v, 16'h0009);
    trig_i = 1'b1;
    cnt_pin_i = 1'b1;
    wait_cyc(4);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_map;
    logic [7:0] d;
    wr(3'd0, 8'hB0);
    rd(3'd0, d);
    check("R11 reserved bits read 0", {8'h0, d}, 16'h0080);
    wr(3'd2, 8'h5A);
    rd(3'd2, d);
    check("R11 holding high byte", {8'h0, d}, 16'h005A);
    wr(3'd0, 8'h00);
  endtask

  initial begin
    wait_cyc(3);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_fast_and_off();
    t_slow();
    t_reload();
    t_free_wrap();
    t_capture();
    t_ignored();
    t_counter_and_same_cycle();
    t_map();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule